// File: doc/BRIEF.md
# Reset-Strap Boot Configuration Router

This block decides, once per reset, how a bridge chip starts up. Two strap inputs are watched while reset is held. One picks the bridge role: host or agent. The other picks where the boot ROM lives: behind the local memory port or out in PCI memory space. The role fixes the power-on value of the master-enable and target-enable bits in a small PCI-style command register. The ROM location fixes which port receives every instruction fetch that the processor core issues through the boot fetch interface.

Fetches use a valid/ready handshake. A fetch routed to PCI can only leave on the PCI master port while the command register's master-enable bit is set. Otherwise the fetch is held, with ready low, until that bit is written. In agent mode the bit starts clear, so a core booting from PCI waits until an outside host grants it mastership. Software or an outside host changes the register through a plain write-enable and data port.

Top module: `boot_cfg_router`

## Requirements
- R1: When the role strap is high while reset is held, the command register reads 3'b100 after reset: bit 2 (master enable) is 1 and bit 1 (target enable) is 0.
- R2: When the role strap is low while reset is held, the command register reads 3'b000 after reset, so both master and target are disabled.
- R3: When the ROM strap is high while reset is held, `route_pci` is 0. Fetches then go to the ROM port: `rom_valid` follows `fetch_valid`, `rom_addr` equals `fetch_addr`, and `pci_valid` stays 0.
- R4: When the ROM strap is low while reset is held, `route_pci` is 1. Fetches then go to the PCI master port with `pci_addr` equal to `fetch_addr`, unchanged, and `rom_valid` stays 0.
- R5: In agent mode with the ROM on PCI, a pending fetch sees `fetch_ready` low and `pci_valid` low. One clock after bit 2 of the command register is written to 1, the fetch is presented on the PCI port and is accepted when `pci_ready` is high.
- R6: `pci_valid` is never 1 while command bit 2 is 0. This holds in host mode too, after software has cleared the bit.
- R7: Both straps are sampled on every clock edge while `rst_n` is low. The values seen at the last reset edge are frozen, and strap changes after reset has been released have no effect on `route_pci` or on routing.
- R8: A write with `cmd_we` high loads bits 2 and 1 of `cmd_wdata` into the command register on the next clock edge. Bit 0 of the register always reads 0, whatever is written to it.
- R9: `pci_master_ok` always equals command bit 2.
- R10: With the ROM on the local port, `fetch_ready` equals `rom_ready` whatever the master-enable bit, so an agent with mastership disabled still boots from local ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_role | input | 1 | Role strap: 1 host, 0 agent |
| strap_rom_local | input | 1 | ROM strap: 1 local memory port, 0 PCI space |
| fetch_valid | input | 1 | Core fetch request valid |
| fetch_addr | input | ADDR_W | Core fetch address |
| fetch_ready | output | 1 | Fetch accepted by the selected port |
| rom_valid | output | 1 | Request to local ROM port |
| rom_addr | output | ADDR_W | Address to local ROM port |
| rom_ready | input | 1 | Local ROM port ready |
| pci_valid | output | 1 | Request to PCI master port |
| pci_addr | output | ADDR_W | Address to PCI master port |
| pci_ready | input | 1 | PCI master port ready |
| cmd_we | input | 1 | Command register write enable |
| cmd_wdata | input | 3 | Command register write data |
| cmd_q | output | 3 | Command register value |
| route_pci | output | 1 | 1 when fetches are steered to PCI |
| pci_master_ok | output | 1 | PCI master transactions allowed |

## Verification
The hardest case to reach is a fetch stalled in agent mode with the ROM on PCI. The stall must last several cycles before mastership is granted through a command write, and the fetch must then go out on PCI the cycle after that write. The bench gets there by holding the role and ROM straps low through reset. It keeps `fetch_valid` high with `pci_ready` high and watches ready stay low. Only then does it write bit 2, and it checks the handoff at the next clock. Freezing of the straps is shown by changing them inside reset and again after release.

// File: rtl/boot_cfg_pkg.sv
// Shared constants and types for the boot configuration router.
// Assumes a 3-bit view of the command register; only bits 2 and 1 hold state.
package boot_cfg_pkg;
    localparam int CMD_W      = 3;
    localparam int MASTER_BIT = 2;
    localparam int TARGET_BIT = 1;
    localparam int NUM_STRAPS = 2;
    localparam int STRAP_ROLE = 0;
    localparam int STRAP_ROM  = 1;

    typedef enum logic { ROLE_AGENT = 1'b0, ROLE_HOST = 1'b1 } role_e;

    localparam logic [CMD_W-1:0] CMD_HOST_INIT  = 3'b100;
    localparam logic [CMD_W-1:0] CMD_AGENT_INIT = 3'b000;
endpackage

// File: rtl/strap_latch.sv
// Samples strap pins on every clock edge while reset is held and keeps the
// last sampled value once reset is released. Assumes the straps are stable
// around the deasserting edge.
module strap_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] held
);
    for (genvar g = 0; g < N; g++) begin : g_strap
        // Track the pin during reset, hold afterwards.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[g] <= pins[g];
            end
        end
    end
endmodule

// File: rtl/cmd_reg.sv
// Command register holding master-enable and target-enable. Its reset value
// depends on the role strap pin seen during reset. Bit 0 is constant zero.
module cmd_reg
    import boot_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_pin,
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] q
);
    logic master_q;
    logic target_q;
    logic [CMD_W-1:0] init_val;

    // Reset image chosen by role.
    always_comb init_val = (role_e'(role_pin) == ROLE_HOST) ? CMD_HOST_INIT : CMD_AGENT_INIT;

    // Load reset image, then accept writes to the two modelled bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= init_val[MASTER_BIT];
            target_q <= init_val[TARGET_BIT];
        end else if (we) begin
            master_q <= wdata[MASTER_BIT];
            target_q <= wdata[TARGET_BIT];
        end
    end

    // Assemble the visible register.
    always_comb begin
        q             = '0;
        q[MASTER_BIT] = master_q;
        q[TARGET_BIT] = target_q;
    end
endmodule

// File: rtl/fetch_steer.sv
// Steers core fetches to the local ROM port or the PCI master port. A PCI
// fetch is held (ready low, no request) while master enable is clear.
// Assumes downstream ports follow valid/ready and do not depend on ready.
module fetch_steer #(
    parameter int ADDR_W = 32
) (
    input  logic              route_pci,
    input  logic              master_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              rom_valid,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_ready,
    output logic              pci_valid,
    output logic [ADDR_W-1:0] pci_addr,
    input  logic              pci_ready
);
    logic pci_go;

    // PCI path is open only with mastership.
    always_comb pci_go = route_pci && master_en;

    // Route request and return ready from the selected port.
    always_comb begin
        rom_addr    = fetch_addr;
        pci_addr    = fetch_addr;
        rom_valid   = fetch_valid && !route_pci;
        pci_valid   = fetch_valid && pci_go;
        if (route_pci) begin
            fetch_ready = pci_go && pci_ready;
        end else begin
            fetch_ready = rom_ready;
        end
    end
endmodule

// File: rtl/boot_cfg_router.sv
// Top of the boot configuration router: latches role and ROM straps at reset,
// owns the command register and steers boot fetches accordingly.
module boot_cfg_router
    import boot_cfg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_role,
    input  logic              strap_rom_local,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              rom_valid,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_ready,
    output logic              pci_valid,
    output logic [ADDR_W-1:0] pci_addr,
    input  logic              pci_ready,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              route_pci,
    output logic              pci_master_ok
);
    logic [NUM_STRAPS-1:0] strap_pins;
    logic [NUM_STRAPS-1:0] strap_held;

    // Gather strap pins into one vector.
    always_comb begin
        strap_pins             = '0;
        strap_pins[STRAP_ROLE] = strap_role;
        strap_pins[STRAP_ROM]  = strap_rom_local;
    end

    strap_latch #(.N(NUM_STRAPS)) i_straps (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (strap_pins),
        .held  (strap_held)
    );

    cmd_reg i_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .role_pin (strap_role),
        .we       (cmd_we),
        .wdata    (cmd_wdata),
        .q        (cmd_q)
    );

    // Derive routing and mastership qualifier.
    always_comb begin
        route_pci     = !strap_held[STRAP_ROM];
        pci_master_ok = cmd_q[MASTER_BIT];
    end

    fetch_steer #(.ADDR_W(ADDR_W)) i_steer (
        .route_pci   (route_pci),
        .master_en   (pci_master_ok),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .fetch_ready (fetch_ready),
        .rom_valid   (rom_valid),
        .rom_addr    (rom_addr),
        .rom_ready   (rom_ready),
        .pci_valid   (pci_valid),
        .pci_addr    (pci_addr),
        .pci_ready   (pci_ready)
    );
endmodule

// File: rtl/boot_cfg_router_chk.sv
// Property checker for boot_cfg_router, attached by bind below.
module boot_cfg_router_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_role,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ready,
    input logic              rom_valid,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              pci_valid,
    input logic [ADDR_W-1:0] pci_addr,
    input logic              cmd_we,
    input logic [2:0]        cmd_wdata,
    input logic [2:0]        cmd_q,
    input logic              route_pci,
    input logic              pci_master_ok
);
    logic was_rst;
    logic role_at_rst;

    // Remember that reset was seen and the role strap it sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_rst     <= 1'b1;
            role_at_rst <= strap_role;
        end
    end

    p_no_pci_without_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid |-> cmd_q[2]);

    p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_valid && pci_valid));

    p_route_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && $past(rst_n)) |-> $stable(route_pci));

    p_init_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && $rose(rst_n)) |-> (cmd_q == (role_at_rst ? 3'b100 : 3'b000)));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && $past(rst_n) && $past(cmd_we)) |-> (cmd_q[2:1] == $past(cmd_wdata[2:1])));

    p_bit0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[0] == 1'b0);

    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route_pci && !pci_master_ok) |-> (!fetch_ready && !pci_valid));

    p_qualifier_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pci_master_ok == cmd_q[2]);

    p_addr_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid |-> (pci_addr == fetch_addr && fetch_valid));

    p_rom_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_valid |-> (rom_addr == fetch_addr && !route_pci));
endmodule

bind boot_cfg_router boot_cfg_router_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_role    (strap_role),
    .fetch_valid   (fetch_valid),
    .fetch_addr    (fetch_addr),
    .fetch_ready   (fetch_ready),
    .rom_valid     (rom_valid),
    .rom_addr      (rom_addr),
    .pci_valid     (pci_valid),
    .pci_addr      (pci_addr),
    .cmd_we        (cmd_we),
    .cmd_wdata     (cmd_wdata),
    .cmd_q         (cmd_q),
    .route_pci     (route_pci),
    .pci_master_ok (pci_master_ok)
);

// File: tb/test_boot_cfg_router.sv
// Self-checking bench for boot_cfg_router.
module test_boot_cfg_router;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_role = 1'b0;
    logic          strap_rom_local = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_ready;
    logic          rom_valid;
    logic [AW-1:0] rom_addr;
    logic          rom_ready = 1'b0;
    logic          pci_valid;
    logic [AW-1:0] pci_addr;
    logic          pci_ready = 1'b0;
    logic          cmd_we = 1'b0;
    logic [2:0]    cmd_wdata = '0;
    logic [2:0]    cmd_q;
    logic          route_pci;
    logic          pci_master_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_cfg_router #(.ADDR_W(AW)) i_boot_cfg_router (
        .clk, .rst_n, .strap_role, .strap_rom_local, .fetch_valid, .fetch_addr,
        .fetch_ready, .rom_valid, .rom_addr, .rom_ready, .pci_valid, .pci_addr,
        .pci_ready, .cmd_we, .cmd_wdata, .cmd_q, .route_pci, .pci_master_ok
    );

    // {role, rom_local, exp cmd[2], exp cmd[1], exp route_pci}
    localparam logic [4:0] VEC [4] = '{5'b11100, 5'b10101, 5'b01000, 5'b00001};

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold reset three edges with given straps, release at a falling edge,
    // then wait for the first edge with reset high.
    task automatic do_reset(input logic role, input logic rom);
        @(negedge clk);
        rst_n = 1'b0;
        strap_role = role;
        strap_rom_local = rom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_cmd(input logic [2:0] v);
        cmd_we = 1'b1;
        cmd_wdata = v;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    initial begin
        // Table-driven pass over all four strap combinations.
        for (int i = 0; i < 4; i++) begin
            logic [4:0] v;
            v = VEC[i];
            do_reset(v[4], v[3]);
            chk("R1/R2 cmd after reset", AW'(cmd_q), AW'({v[2], v[1], 1'b0}));
            chk("R9 qualifier", AW'(pci_master_ok), AW'(v[2]));
            chk("R3/R4 route", AW'(route_pci), AW'(v[0]));
            fetch_valid = 1'b1;
            fetch_addr  = 32'hFFF0_0100 + AW'(i);
            rom_ready   = 1'b1;
            pci_ready   = 1'b1;
            #1;
            if (v[0]) begin
                chk("R4 pci_valid", AW'(pci_valid), AW'(v[2]));
                chk("R4 rom idle", AW'(rom_valid), 0);
                chk("R4 pci_addr unchanged", pci_addr, 32'hFFF0_0100 + AW'(i));
                chk("R6 ready gated", AW'(fetch_ready), AW'(v[2]));
            end else begin
                chk("R3 rom_valid", AW'(rom_valid), 1);
                chk("R3 pci idle", AW'(pci_valid), 0);
                chk("R3 rom_addr", rom_addr, 32'hFFF0_0100 + AW'(i));
                chk("R10 ready from rom", AW'(fetch_ready), 1);
            end
            fetch_valid = 1'b0;
        end

        // R10: agent, local ROM, master off, ready follows rom_ready.
        do_reset(1'b0, 1'b1);
        fetch_valid = 1'b1;
        rom_ready = 1'b0;
        #1 chk("R10 ready low", AW'(fetch_ready), 0);
        rom_ready = 1'b1;
        #1 chk("R10 ready high", AW'(fetch_ready), 1);
        fetch_valid = 1'b0;

        // R5: agent + PCI ROM stalls until master bit written.
        do_reset(1'b0, 1'b0);
        fetch_valid = 1'b1;
        fetch_addr = 32'hFFF0_0000;
        pci_ready = 1'b1;
        repeat (4) begin
            #1 chk("R5 stalled ready", AW'(fetch_ready), 0);
            chk("R5 stalled valid", AW'(pci_valid), 0);
            @(negedge clk);
        end
        write_cmd(3'b100);
        chk("R5 granted valid", AW'(pci_valid), 1);
        chk("R5 granted ready", AW'(fetch_ready), 1);
        chk("R5 addr", pci_addr, 32'hFFF0_0000);
        chk("R9 qualifier set", AW'(pci_master_ok), 1);
        pci_ready = 1'b0;
        #1 chk("R5 waits pci_ready", AW'(fetch_ready), 0);
        pci_ready = 1'b1;
        fetch_valid = 1'b0;

        // R8: bit 0 ignored, bits 2:1 written.
        write_cmd(3'b011);
        chk("R8 write bit0 ignored", AW'(cmd_q), 3'b010);
        write_cmd(3'b111);
        chk("R8 write both", AW'(cmd_q), 3'b110);

        // R6: host with PCI ROM, software clears master.
        do_reset(1'b1, 1'b0);
        fetch_valid = 1'b1;
        #1 chk("R6 host pci go", AW'(pci_valid), 1);
        @(negedge clk);
        write_cmd(3'b000);
        chk("R6 cleared no pci", AW'(pci_valid), 0);
        chk("R6 cleared ready", AW'(fetch_ready), 0);
        chk("R9 qualifier clear", AW'(pci_master_ok), 0);
        fetch_valid = 1'b0;

        // R7: strap changed during reset uses last value; change after is ignored.
        @(negedge clk);
        rst_n = 1'b0;
        strap_role = 1'b1;
        strap_rom_local = 1'b0;
        @(negedge clk);
        strap_role = 1'b0;
        strap_rom_local = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 last role used", AW'(cmd_q), 3'b000);
        chk("R7 last rom used", AW'(route_pci), 0);
        strap_rom_local = 1'b0;
        strap_role = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 route frozen", AW'(route_pci), 0);
        fetch_valid = 1'b1;
        #1 chk("R7 still rom", AW'(rom_valid), 1);
        chk("R7 cmd untouched", AW'(cmd_q), 3'b000);
        fetch_valid = 1'b0;

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule